// File: doc/BRIEF.md
# RC Timing Converter Sequencer

This block runs a low-cost analog-to-digital conversion built from one digital output, a resistor, a capacitor and a comparator. The output pin charges the capacitor towards supply and discharges it towards ground. The capacitor voltage feeds the comparator's non-inverting input, and the unknown voltage feeds the inverting input. The sequencer counts fixed sample periods from the moment the pin changes level. When the comparator reports that the capacitor has crossed the unknown voltage, the sample index is turned into a voltage code by a table lookup. No arithmetic is done at run time.

A conversion first uses the rising (charge) slope, which resolves inputs below mid-supply. If nothing trips there, the capacitor is parked at supply and the falling (discharge) slope is used, which resolves inputs above mid-supply. Each slope gets more sample slots than a nominal network needs to reach mid-supply, so a fast network that overshoots is still covered. Before each slope the pin is held steady for a settle period, so that the capacitor starts from a known rail. With the default parameters at a 12 MHz clock, one sample is 5 µs, one settle is 3 ms, and the worst-case conversion takes under 7 ms.

The result leaves as a valid-only stream: `done_o` is the valid strobe, and there is no ready and no back-pressure. The consumer must take `code_o` in the cycle `done_o` is high. `code_o` and `overrange_o` then hold until the next result.

Top module: `rcadc_seq`

## Requirements
- R1: When idle, a high `start_i` on a clock edge starts a conversion. `busy_o` is high from the next cycle, and `charge_o` is driven low for SETTLE_CYC cycles.
- R2: A `start_i` pulse that arrives while `busy_o` is high is ignored. The conversion in progress keeps its timing and result.
- R3: After the low settle, `charge_o` goes high. Charge slot n (0 ≤ n < SLOTS) samples `comp_i` on the edge SETTLE_CYC+1+n·SAMPLE_DIV cycles after the accepting edge. A high `comp_i` there ends the conversion with charge-table entry n.
- R4: If no charge slot trips, `charge_o` stays high for another SETTLE_CYC cycles and then goes low. Discharge slot n is sampled SETTLE_CYC+1+n·SAMPLE_DIV cycles after the last charge slot. A low `comp_i` there ends the conversion with discharge-table entry n.
- R5: If no discharge slot trips either, the result is the final discharge entry (index SLOTS-1) and `overrange_o` is 1.
- R6: The table holds codes in tenths of a volt, from 0 to FULL_SCALE. For slot n, the discharge code is round(q_n / 65536), where q_0 = FULL_SCALE·65536 and q_{k+1} = floor(q_k·DECAY_Q16 / 65536). The charge code is FULL_SCALE minus the discharge code. Charge entries occupy indices 0..SLOTS-1 and discharge entries occupy indices SLOTS..2·SLOTS-1.
- R7: `done_o` is high for exactly one cycle per conversion, and `busy_o` falls in that same cycle. `code_o` and `overrange_o` change only when `done_o` is high. `overrange_o` is 0 for any result from a trip.
- R8: After reset: `busy_o`, `done_o`, `charge_o` and `overrange_o` are 0, and `code_o` is 0.
- R9: `comp_i` has no effect during either settle period.
- R10: While idle, `charge_o` keeps the level it had at the end of the last conversion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Conversion request, sampled on each edge |
| comp_i | input | 1 | Comparator output, high when capacitor voltage exceeds the unknown voltage |
| charge_o | output | 1 | Drive pin for the RC network, 1 charges and 0 discharges |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle valid strobe for the result |
| code_o | output | CODE_W | Result in tenths of a volt |
| overrange_o | output | 1 | Neither slope tripped; the result is saturated |

## Verification
The bench uses SETTLE_CYC=20 and SAMPLE_DIV=4. For a charge trip at slot n, `done_o` is due SETTLE_CYC+1+4n edges after the accepting edge. For a discharge trip, that count grows by a full charge window plus a second settle. A reference model, advanced on every rising edge, tracks the cycles since acceptance and predicts `busy_o`, `charge_o`, `done_o`, `code_o` and `overrange_o`. The design outputs are compared with it on every falling edge, so each result is checked in the very cycle it is due and not a cycle either side. The comparator stimulus is built from the cycles since the pin last toggled, so a trip lands exactly on the chosen slot. An optional noise mode inverts `comp_i` only during settle periods.

// File: rtl/rcadc_pkg.sv
package rcadc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_RUN    = 2'd2
  } rc_state_e;

  // Voltage code for one table index, using the fixed-point decay recurrence.
  function automatic int unsigned rc_code(int unsigned idx, int unsigned slots,
                                          int unsigned full, int unsigned ratio);
    longint unsigned q;
    int unsigned     n;
    int unsigned     fall;
    n = (idx < slots) ? idx : idx - slots;
    q = longint'(full) << 16;
    for (int unsigned k = 0; k < n; k++) q = (q * ratio) >> 16;
    fall = 32'((q + 64'd32768) >> 16);
    return (idx < slots) ? full - fall : fall;
  endfunction

endpackage

// File: rtl/rcadc_pacer.sv
module rcadc_pacer #(
  parameter int SAMPLE_DIV = 60,
  parameter int SLOTS      = 79,
  parameter int SETTLE_CYC = 36000
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       restart_i,
  input  logic                       running_i,
  output logic                       settle_end_o,
  output logic                       sample_now_o,
  output logic                       last_slot_o,
  output logic [$clog2(SLOTS)-1:0]   slot_o
);
  localparam int MAXC   = (SETTLE_CYC > SAMPLE_DIV) ? SETTLE_CYC : SAMPLE_DIV;
  localparam int CNT_W  = $clog2(MAXC + 1);
  localparam int SLOT_W = $clog2(SLOTS);

  logic [CNT_W-1:0]  cnt_q;
  logic [SLOT_W-1:0] slot_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      slot_q <= '0;
    end else if (restart_i) begin
      cnt_q  <= '0;
      slot_q <= '0;
    end else if (!running_i) begin
      cnt_q  <= cnt_q + 1'b1;
    end else if (cnt_q == CNT_W'(SAMPLE_DIV - 1)) begin
      cnt_q  <= '0;
      slot_q <= slot_q + 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign settle_end_o = !running_i && (cnt_q == CNT_W'(SETTLE_CYC - 1));
  assign sample_now_o = running_i && (cnt_q == '0);
  assign last_slot_o  = (slot_q == SLOT_W'(SLOTS - 1));
  assign slot_o       = slot_q;
endmodule

// File: rtl/rcadc_table.sv
module rcadc_table #(
  parameter int SLOTS      = 79,
  parameter int CODE_W     = 6,
  parameter int FULL_SCALE = 50,
  parameter int DECAY_Q16  = 64925
) (
  input  logic [$clog2(2*SLOTS)-1:0] idx_i,
  output logic [CODE_W-1:0]          code_o
);
  localparam int ENTRIES = 2 * SLOTS;

  logic [CODE_W-1:0] rom [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
    assign rom[i] = CODE_W'(rcadc_pkg::rc_code(i, SLOTS, FULL_SCALE, DECAY_Q16));
  end

  assign code_o = rom[idx_i];
endmodule

// File: rtl/rcadc_seq.sv
module rcadc_seq #(
  parameter int SAMPLE_DIV = 60,
  parameter int SLOTS      = 79,
  parameter int SETTLE_CYC = 36000,
  parameter int CODE_W     = 6,
  parameter int FULL_SCALE = 50,
  parameter int DECAY_Q16  = 64925
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              comp_i,
  output logic              charge_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [CODE_W-1:0] code_o,
  output logic              overrange_o
);
  import rcadc_pkg::*;

  localparam int SLOT_W = $clog2(SLOTS);
  localparam int IDX_W  = $clog2(2 * SLOTS);

  rc_state_e         state_q;
  logic              falling_q;   // 0: charge slope, 1: discharge slope
  logic              pin_q, done_q, ovr_q;
  logic [CODE_W-1:0] code_q;

  logic              settle_end, sample_now, last_slot, trip, restart;
  logic [SLOT_W-1:0] slot;
  logic [IDX_W-1:0]  idx;
  logic [CODE_W-1:0] tbl_code;

  assign trip    = falling_q ? !comp_i : comp_i;
  assign restart = ((state_q == ST_IDLE) && start_i) ||
                   ((state_q == ST_SETTLE) && settle_end) ||
                   ((state_q == ST_RUN) && sample_now && !trip && last_slot && !falling_q);
  assign idx     = falling_q ? IDX_W'(SLOTS) + IDX_W'(slot) : IDX_W'(slot);

  rcadc_pacer #(.SAMPLE_DIV(SAMPLE_DIV), .SLOTS(SLOTS), .SETTLE_CYC(SETTLE_CYC)) u_pacer (
    .clk          (clk),
    .rst_n        (rst_n),
    .restart_i    (restart),
    .running_i    (state_q == ST_RUN),
    .settle_end_o (settle_end),
    .sample_now_o (sample_now),
    .last_slot_o  (last_slot),
    .slot_o       (slot)
  );

  rcadc_table #(.SLOTS(SLOTS), .CODE_W(CODE_W), .FULL_SCALE(FULL_SCALE),
                .DECAY_Q16(DECAY_Q16)) u_table (
    .idx_i  (idx),
    .code_o (tbl_code)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      falling_q <= 1'b0;
      pin_q     <= 1'b0;
      done_q    <= 1'b0;
      ovr_q     <= 1'b0;
      code_q    <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q   <= ST_SETTLE;
          falling_q <= 1'b0;
          pin_q     <= 1'b0;
        end
        ST_SETTLE: if (settle_end) begin
          state_q <= ST_RUN;
          pin_q   <= !falling_q;
        end
        ST_RUN: if (sample_now) begin
          if (trip) begin
            code_q  <= tbl_code;
            ovr_q   <= 1'b0;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else if (last_slot) begin
            if (!falling_q) begin
              falling_q <= 1'b1;     // pin stays high while parked at supply
              state_q   <= ST_SETTLE;
            end else begin
              code_q  <= tbl_code;   // final discharge entry
              ovr_q   <= 1'b1;
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign charge_o    = pin_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign code_o      = code_q;
  assign overrange_o = ovr_q;
endmodule

// File: rtl/rcadc_seq_chk.sv
module rcadc_seq_chk #(
  parameter int CODE_W     = 6,
  parameter int FULL_SCALE = 50
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              charge_o,
  input logic              busy_o,
  input logic              done_o,
  input logic [CODE_W-1:0] code_o,
  input logic              overrange_o
);
  assert_busy_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));

  assert_settle_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> !charge_o);

  assert_code_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    code_o <= CODE_W'(FULL_SCALE));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  assert_code_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(code_o) |-> done_o);

  assert_ovr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(overrange_o) |-> done_o);

  assert_pin_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(charge_o));
endmodule

bind rcadc_seq rcadc_seq_chk #(.CODE_W(CODE_W), .FULL_SCALE(FULL_SCALE)) u_chk (.*);

// File: tb/rcadc_seq_tb.sv
module rcadc_seq_tb;
  localparam int D  = 4;
  localparam int L  = 79;
  localparam int S  = 20;
  localparam int FS = 50;

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, comp_i = 1'b0;
  logic charge_o, busy_o, done_o, overrange_o;
  logic [5:0] code_o;

  always #2 clk = ~clk;  // 250 MHz

  rcadc_seq #(.SAMPLE_DIV(D), .SLOTS(L), .SETTLE_CYC(S), .CODE_W(6),
              .FULL_SCALE(FS), .DECAY_Q16(64925)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .comp_i(comp_i),
    .charge_o(charge_o), .busy_o(busy_o), .done_o(done_o),
    .code_o(code_o), .overrange_o(overrange_o));

  int checks = 0, errors = 0, done_seen = 0, conv_req = 0;
  int chg_t[L], dis_t[L];
  int ct = -1, dt = -1;
  bit noise = 0;

  // reference model state
  bit m_busy = 0, m_done = 0, m_pin = 0, m_ovr = 0, m_fall = 0;
  int m_code = 0, t = 0;
  bit last_pin = 0;
  int since = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // R6: table from the decay recurrence
  initial begin
    longint unsigned q = 64'(FS) << 16;
    for (int n = 0; n < L; n++) begin
      dis_t[n] = int'((q + 64'd32768) >> 16);
      chg_t[n] = FS - dis_t[n];
      q = (q * 64'd64925) >> 16;
    end
  end

  task automatic m_finish(int c, bit o);
    m_busy = 0; m_done = 1; m_code = c; m_ovr = o;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_pin = 0; m_ovr = 0; m_code = 0; m_fall = 0; t = 0;
    end else begin
      m_done = 0;
      if (!m_busy) begin
        if (start_i) begin m_busy = 1; t = 0; m_pin = 0; m_fall = 0; end
      end else begin
        t++;
        if (!m_fall) begin
          if (t == S) m_pin = 1;
          if (ct >= 0 && ct < L && t == S + 1 + ct * D) m_finish(chg_t[ct], 0);
          else if (t == S + 1 + (L - 1) * D) begin m_fall = 1; t = 0; end
        end else begin
          if (t == S) m_pin = 0;
          if (dt >= 0 && dt < L && t == S + 1 + dt * D) m_finish(dis_t[dt], 0);
          else if (t == S + 1 + (L - 1) * D) m_finish(dis_t[L - 1], 1);
        end
      end
    end
  end

  // per-cycle comparison and comparator drive
  always @(negedge clk) begin
    bit base;
    if (rst_n) begin
      chk(busy_o == m_busy, "R1/R2", "busy_o", busy_o, m_busy);
      chk(charge_o == m_pin, "R1/R3/R4/R10", "charge_o", charge_o, m_pin);
      chk(done_o == m_done, "R3/R4/R5/R7", "done_o", done_o, m_done);
      chk(code_o == m_code, "R3/R4/R5/R6", "code_o", code_o, m_code);
      chk(overrange_o == m_ovr, "R5/R7", "overrange_o", overrange_o, m_ovr);
      if (done_o) done_seen++;
    end
    if (charge_o != last_pin) since = 0; else since++;
    last_pin = charge_o;
    base = charge_o ? (ct >= 0 && since >= ct * D) : !(dt >= 0 && since >= dt * D);
    if (noise && m_busy && t < S) base = !base;  // R9: flip only during settle
    comp_i = base;
  end

  task automatic run(int c, int d, bit nz, bit extra);
    @(negedge clk);
    ct = c; dt = d; noise = nz; start_i = 1'b1; conv_req++;
    @(negedge clk);
    start_i = 1'b0;
    if (extra) begin  // R2: second request while busy
      repeat (50) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    forever begin
      @(negedge clk);
      if (m_done) break;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: reset state
    chk(busy_o == 0 && done_o == 0 && charge_o == 0, "R8", "ctrl", {busy_o, done_o, charge_o}, 0);
    chk(code_o == 0 && overrange_o == 0, "R8", "code/ovr", code_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run(0, -1, 0, 0);    // R3 first slot
    run(10, -1, 0, 0);   // R3
    run(78, -1, 1, 1);   // R3 last slot, R9 noise, R2 extra start
    run(-1, 0, 0, 0);    // R4 first discharge slot
    run(-1, 40, 1, 1);   // R4, R9, R2
    run(-1, 78, 0, 0);   // R4 last slot
    run(-1, -1, 0, 0);   // R5 overrange
    run(5, -1, 0, 0);    // R7 overrange clears
    run(30, -1, 0, 1);   // R2
    repeat (10) @(negedge clk);  // R10 idle hold checked per cycle
    chk(done_seen == conv_req, "R7", "done pulses", done_seen, conv_req);
    summary();
  end
endmodule